// File: doc/BRIEF.md
# Rank Activate Spacing and Window Limiter

This block paces row-activate commands for a single rank of a DRAM channel. It enforces two rules at once: a minimum number of cycles between any two activates in the rank, and a cap on how many activates may land inside any sliding window of a fixed number of cycles. The command stage raises a request when it wants to open a row. The block answers with a permission signal. When the command stage actually sends the activate, it pulses the fire input.

Each rank gets its own instance. The spacing, the window length and the cap are parameters counted in clock cycles. A window length of zero switches the window rule off and leaves only the spacing rule. Inside the block, the ages of the most recent activates are kept in a small ring of slots, one slot per activate allowed in a window. Permission is combinational from that registered state and from the request, so it reflects a fire in the very next cycle. If an activate is fired without permission, a sticky error flag is raised.

Top module: `act_window_limiter`

## Requirements
- R1: `act_ok` is high exactly when `act_req` is high and both the spacing rule and the window rule are met. It is low in every cycle in which `act_req` is low.
- R2: After an activate fired at clock edge t, `act_ok` stays low until at least GAP_CYC cycles have passed since t. Once GAP_CYC cycles have passed, the spacing rule no longer blocks. A GAP_CYC of 0 or 1 allows back-to-back activates.
- R3: With WIN_CYC greater than zero, once ACT_CAP activates are on record, a further activate is allowed only when the oldest of the last ACT_CAP activates was fired at least WIN_CYC cycles earlier.
- R4: With WIN_CYC equal to zero, the window rule never blocks, whatever the number of activates. Only the spacing rule applies.
- R5: After reset no activate is on record. The very first request is granted at once, and the first ACT_CAP activates are limited only by the spacing rule.
- R6: A fire pulse in a cycle where `act_ok` is low sets `err_flag`. The flag then stays high until reset.
- R7: A synchronous active-low reset clears `err_flag` and the activate history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| act_req | input | 1 | Command stage wants to issue an activate this cycle |
| act_fire | input | 1 | An activate is issued to the rank at this clock edge |
| act_ok | output | 1 | Activate permitted this cycle |
| err_flag | output | 1 | Sticky flag: an activate was fired without permission |

## Verification
The bench builds two instances side by side.

The first uses a cap of 4, a window of 20 cycles and a spacing of 3. Four activates at full rate then span only 9 cycles, so the window rule is what stops the fifth. The bench therefore reaches the exact cycle at which the oldest slot ages out.

The second uses a cap of 2, a window of zero and a spacing of 5. Long trains of activates run there that would break any cap if the window were not disabled, and the spacing boundary is checked on a longer interval.

// File: rtl/act_lim_pkg.sv
// Package: shared helpers for the rank activate limiter.
// Assumes: counts are non-negative cycle numbers.
package act_lim_pkg;

    // Bits needed to hold a saturating count of up to lim (at least one bit).
    function automatic int cnt_width(input int lim);
        return (lim < 1) ? 1 : $clog2(lim + 1);
    endfunction

    // Bits needed to index a ring of n slots (at least one bit).
    function automatic int ptr_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/act_gap_timer.sv
// Module: tracks the age of the latest activate and opens once GAP_CYC
// cycles have passed since it was fired.
// Assumes: fire is a single-cycle strobe per issued activate.
module act_gap_timer #(
    parameter int GAP_CYC = 8,
    parameter int CNT_W   = act_lim_pkg::cnt_width(GAP_CYC)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic open
);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(GAP_CYC);

    logic             seen;
    logic [CNT_W-1:0] age;

    // Restart the age on each fire, then count up and saturate at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= 1'b0;
            age  <= '0;
        end else if (fire) begin
            seen <= 1'b1;
            age  <= CNT_W'(1);
        end else if (seen && (age < LIM)) begin
            age <= age + CNT_W'(1);
        end
    end

    // Open when nothing is on record or the spacing has elapsed.
    always_comb open = !seen || (age >= LIM);

    generate
        if (GAP_CYC >= 2) begin : g_gap_chk
            // R2
            gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                fire |=> !open);
        end
    endgenerate

endmodule

// File: rtl/act_win_slot.sv
// Module: one ring slot holding the age of a recorded activate.
// Assumes: load marks a new activate; age saturates at LIM_CYC.
module act_win_slot #(
    parameter int LIM_CYC = 40,
    parameter int CNT_W   = act_lim_pkg::cnt_width(LIM_CYC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    output logic             valid,
    output logic [CNT_W-1:0] age
);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(LIM_CYC);

    // Load a fresh age on a new activate, otherwise age a valid entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            age   <= '0;
        end else if (load) begin
            valid <= 1'b1;
            age   <= CNT_W'(1);
        end else if (valid && (age < LIM)) begin
            age <= age + CNT_W'(1);
        end
    end

endmodule

// File: rtl/act_win_ring.sv
// Module: ring of ACT_CAP slot ages. It opens when the ring is not full
// or the oldest slot is at least WIN_CYC cycles old. WIN_CYC = 0 disables it.
// Assumes: ACT_CAP >= 1; fire is a single-cycle strobe.
module act_win_ring #(
    parameter int ACT_CAP = 4,
    parameter int WIN_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic open
);
    localparam int CNT_W = act_lim_pkg::cnt_width(WIN_CYC);
    localparam int PTR_W = act_lim_pkg::ptr_width(ACT_CAP);

    generate
        if (WIN_CYC == 0) begin : g_off
            logic unused_in;
            assign unused_in = ^{clk, rst_n, fire};
            assign open = 1'b1;
        end else begin : g_on
            logic [PTR_W-1:0] wptr;
            logic             vld [ACT_CAP];
            logic [CNT_W-1:0] age [ACT_CAP];

            // Advance the write slot on every fire, wrapping at the cap.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    wptr <= '0;
                end else if (fire) begin
                    wptr <= (wptr == PTR_W'(ACT_CAP - 1)) ? '0 : wptr + PTR_W'(1);
                end
            end

            for (genvar i = 0; i < ACT_CAP; i++) begin : g_slot
                logic             s_vld;
                logic [CNT_W-1:0] s_age;
                act_win_slot #(.LIM_CYC(WIN_CYC), .CNT_W(CNT_W)) u_slot (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .load  (fire && (wptr == PTR_W'(i))),
                    .valid (s_vld),
                    .age   (s_age)
                );
                assign vld[i] = s_vld;
                assign age[i] = s_age;
            end

            // The write slot also holds the oldest entry once the ring is full.
            always_comb open = !vld[wptr] || (age[wptr] >= CNT_W'(WIN_CYC));

            // R3
            slot_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
                fire |=> (vld[$past(wptr)] && (age[$past(wptr)] == CNT_W'(1))));
        end
    endgenerate

endmodule

// File: rtl/act_window_limiter.sv
// Module: per-rank activate limiter. Combines the spacing timer and the
// rolling window ring into a permission signal, and flags unpermitted fires.
// Assumes: one instance per rank; parameters are in clock cycles.
module act_window_limiter #(
    parameter int ACT_CAP = 4,
    parameter int WIN_CYC = 40,
    parameter int GAP_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_req,
    input  logic act_fire,
    output logic act_ok,
    output logic err_flag
);
    logic gap_open;
    logic win_open;

    act_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (act_fire),
        .open  (gap_open)
    );

    act_win_ring #(.ACT_CAP(ACT_CAP), .WIN_CYC(WIN_CYC)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (act_fire),
        .open  (win_open)
    );

    // Grant only a present request that both rules allow.
    always_comb act_ok = act_req && gap_open && win_open;

    // Latch any fire that arrives without permission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
        end else if (act_fire && !act_ok) begin
            err_flag <= 1'b1;
        end
    end

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    // R6
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_fire && !act_ok) |=> err_flag);

endmodule

// File: tb/act_window_limiter_tb.sv
module act_window_limiter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CAP_A = 4, WIN_A = 20, GAP_A = 3;
    localparam int CAP_B = 2, WIN_B = 0,  GAP_B = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_a = 1'b0, fire_a = 1'b0, ok_a, err_a;
    logic req_b = 1'b0, fire_b = 1'b0, ok_b, err_b;

    int total = 0;
    int bad = 0;
    int tnow = 0;
    bit done = 1'b0;

    int hist [2][4];
    int hcnt [2];
    int hptr [2];
    int last [2];
    bit seen [2];
    bit merr [2];
    bit eok  [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    act_window_limiter #(.ACT_CAP(CAP_A), .WIN_CYC(WIN_A), .GAP_CYC(GAP_A)) u_dut (
        .clk(clk), .rst_n(rst_n), .act_req(req_a), .act_fire(fire_a),
        .act_ok(ok_a), .err_flag(err_a));

    act_window_limiter #(.ACT_CAP(CAP_B), .WIN_CYC(WIN_B), .GAP_CYC(GAP_B)) u_dut_nowin (
        .clk(clk), .rst_n(rst_n), .act_req(req_b), .act_fire(fire_b),
        .act_ok(ok_b), .err_flag(err_b));

    function automatic int cap_of(input int k); return (k == 0) ? CAP_A : CAP_B; endfunction
    function automatic int win_of(input int k); return (k == 0) ? WIN_A : WIN_B; endfunction
    function automatic int gap_of(input int k); return (k == 0) ? GAP_A : GAP_B; endfunction

    function automatic bit gap_pass(input int k);
        return !seen[k] || ((tnow - last[k]) >= gap_of(k));
    endfunction

    function automatic bit win_pass(input int k);
        if (win_of(k) == 0) return 1'b1;
        if (hcnt[k] < cap_of(k)) return 1'b1;
        return (tnow - hist[k][hptr[k]]) >= win_of(k);
    endfunction

    function automatic string tag_of(input int k, input bit rq);
        if (!rq) return "R1";
        if (!gap_pass(k)) return "R2";
        if (!win_pass(k)) return "R3";
        if (win_of(k) == 0) return "R4";
        if (hcnt[k] < cap_of(k)) return "R5";
        return "R1";
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d cycle=%0d", tag, act, exp, tnow);
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < 2; k++) begin
            hcnt[k] = 0; hptr[k] = 0; last[k] = 0; seen[k] = 1'b0; merr[k] = 1'b0;
        end
        tnow = 0;
    endtask

    task automatic model_fire(input int k);
        if (!eok[k]) merr[k] = 1'b1;
        hist[k][hptr[k]] = tnow;
        hptr[k] = (hptr[k] + 1) % cap_of(k);
        if (hcnt[k] < cap_of(k)) hcnt[k]++;
        last[k] = tnow;
        seen[k] = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_a = 0; req_b = 0; fire_a = 0; fire_b = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
        #1;
        chk("R7", int'(err_a), 0);
        chk("R7", int'(err_b), 0);
    endtask

    // fmode: 0 = no fire, 1 = fire when expected ok, 2 = fire regardless
    task automatic step(input bit ra, input int fa, input bit rb, input int fb);
        @(negedge clk);
        req_a = ra; req_b = rb;
        #1;
        eok[0] = ra && gap_pass(0) && win_pass(0);
        eok[1] = rb && gap_pass(1) && win_pass(1);
        chk(tag_of(0, ra), int'(ok_a), int'(eok[0]));
        chk(tag_of(1, rb), int'(ok_b), int'(eok[1]));
        chk("R6", int'(err_a), int'(merr[0]));
        chk("R6", int'(err_b), int'(merr[1]));
        fire_a = (fa == 2) || ((fa == 1) && eok[0]);
        fire_b = (fb == 2) || ((fb == 1) && eok[1]);
        @(posedge clk);
        if (fire_a) model_fire(0);
        if (fire_b) model_fire(1);
        tnow++;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        model_clear();
        // R7: reset state
        do_reset();
        // R5, R2, R3, R4: full-rate request train, fire whenever allowed
        for (int i = 0; i < 60; i++) step(1'b1, 1, 1'b1, 1);
        // R1: no request, no permission
        for (int i = 0; i < 4; i++) step(1'b0, 0, 1'b0, 0);
        // mixed random traffic
        for (int i = 0; i < 4000; i++) begin
            bit ra = ($urandom % 4) != 0;
            bit rb = ($urandom % 4) != 0;
            int fa = (($urandom % 3) == 0) ? 0 : 1;
            int fb = (($urandom % 3) == 0) ? 0 : 1;
            step(ra, fa, rb, fb);
        end
        // R6: violate spacing right after a legal first fire
        do_reset();
        step(1'b1, 2, 1'b1, 2);
        step(1'b1, 2, 1'b1, 2);
        for (int i = 0; i < 6; i++) step(1'b0, 0, 1'b0, 0);
        // R7: reset clears the sticky flag
        do_reset();
        step(1'b1, 1, 1'b1, 1);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule